// File: doc/BRIEF.md
# Hold-Until-Release Fixed-Priority Bus Arbiter

This block decides which of several bus masters owns a shared bus. Each master raises a request line and waits for its grant line. When nobody owns the bus, the lowest-numbered requesting master wins. With the default of three masters, bit 0 is A (highest priority), bit 1 is B and bit 2 is C (lowest).

Ownership is not preemptive. A master keeps its grant for as long as it holds its request high, even if a higher-priority master starts requesting. When the owner drops its request, the grant register moves straight to the best remaining requester on the next clock edge, with no idle cycle in between. If no other master is requesting, the bus goes idle.

A build parameter can cap how long one master may hold the bus. When an owner reaches that cap while still requesting, its grant is taken away and a one-cycle expiry flag is raised. That master may not win the bus again until it has lowered its request at least once. Pure fixed priority lets a master that never releases block everyone else, and this cap limits that effect. A value of zero removes the cap.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, every grant bit and the expiry flag are 0.
- R2: At most one grant bit is 1 in any cycle.
- R3: From an idle bus, the grant goes to the lowest-indexed requester (bit 0 = A, bit 1 = B, bit 2 = C); when A and B request together, A is granted.
- R4: An owner whose request stays high keeps its grant, and a newly arriving higher-priority request does not take the bus away.
- R5: On the clock edge after the owner's request is seen low, the grant moves directly to the lowest-indexed other eligible requester, or to none if there is none.
- R6: A grant bit rises only for a master whose request was high in the previous cycle, and an idle bus with an eligible requester is granted on the next edge.
- R7: With HOLD_LIMIT = N > 0, an owner that keeps requesting sees its grant high for exactly N cycles. The grant then drops, and `hold_expired` is 1 for exactly the cycle in which the grant is first low.
- R8: A master whose grant expired is not eligible until its request has been low for at least one cycle. At the expiry edge, the grant passes to the best other requester.
- R9: With HOLD_LIMIT = 0, a grant is never revoked and `hold_expired` stays 0.
- R10: An owner that drops its request in the same cycle that would reach the limit releases normally, with no expiry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_MASTERS | Request per master, bit 0 highest priority |
| grant | output | NUM_MASTERS | Registered grant per master, at most one bit set |
| hold_expired | output | 1 | One-cycle pulse when a grant is revoked by the hold limit |

## Verification
Requests from A and B arriving together show whether the fixed order is applied. A higher-priority request arriving under an existing owner shows whether the grant is wrongly preempted. Each release is followed by several different pending sets, which separates a direct hand-over from an idle gap and from a wrong choice of next owner. Holds longer than the limit are run with a competitor pending and with none pending, and are repeated on an instance with the limit disabled. A drop exactly at the limit separates a normal release from a revocation.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Width of a counter able to hold values 0..limit (never below 1)
  function automatic int hold_cnt_width(input int limit);
    int w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NUM_MASTERS = 3
) (
  input  logic [NUM_MASTERS-1:0] cand,
  output logic [NUM_MASTERS-1:0] pick
);
  logic [NUM_MASTERS:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_chain
    assign pick[i]     = cand[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | cand[i];
  end
endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
  parameter int HOLD_LIMIT = 4,
  parameter int CNT_W      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic keep,
  output logic at_limit
);
  logic [CNT_W-1:0] cnt;

  if (HOLD_LIMIT == 0) begin : g_off
    assign at_limit = 1'b0;
  end else begin : g_on
    assign at_limit = (cnt == CNT_W'(HOLD_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= CNT_W'(1);
    else if (keep && !at_limit) cnt <= cnt + CNT_W'(1);
    else if (!keep)           cnt <= '0;
  end

  if (HOLD_LIMIT > 0) begin : g_chk
    // R7: counter never runs beyond the limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(HOLD_LIMIT));
  end
endmodule

// File: rtl/arb_block_tracker.sv
module arb_block_tracker #(
  parameter int NUM_MASTERS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] revoke,
  output logic [NUM_MASTERS-1:0] blocked
);
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) blocked[i] <= 1'b0;
      else     blocked[i] <= req[i] & (blocked[i] | revoke[i]);
    end
    // R8: a block clears once the request is seen low
    p_unblock_r8: assert property (@(posedge clk) disable iff (rst)
      !req[i] |=> !blocked[i]);
  end
endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter #(
  parameter int NUM_MASTERS = 3,
  parameter int HOLD_LIMIT  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req,
  output logic [NUM_MASTERS-1:0] grant,
  output logic                   hold_expired
);
  import arb_pkg::*;
  localparam int CNT_W = hold_cnt_width(HOLD_LIMIT);

  logic                   have_owner, owner_req, at_limit, expire, keep, load;
  logic [NUM_MASTERS-1:0] blocked, eligible, pick, next_grant, revoke;

  assign have_owner = |grant;
  assign owner_req  = |(grant & req);
  assign expire     = owner_req & at_limit;
  assign keep       = owner_req & ~at_limit;
  assign revoke     = expire ? grant : '0;
  assign eligible   = req & ~blocked & ~revoke;
  assign next_grant = keep ? grant : pick;
  assign load       = ~keep & (|pick);

  arb_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .cand(eligible), .pick(pick));

  arb_hold_timer #(.HOLD_LIMIT(HOLD_LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .keep(keep), .at_limit(at_limit));

  arb_block_tracker #(.NUM_MASTERS(NUM_MASTERS)) u_block (
    .clk(clk), .rst(rst), .req(req), .revoke(revoke), .blocked(blocked));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant        <= '0;
      hold_expired <= 1'b0;
    end else begin
      grant        <= next_grant;
      hold_expired <= expire;
    end
  end

  // R2: single owner
  p_one_owner_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R4: a requesting owner below the limit keeps the bus
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (owner_req && !at_limit) |=> $stable(grant));
  // R5: after release the old owner is not re-granted
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (have_owner && !owner_req) |=> ((grant & $past(grant)) == '0));
  // R6: idle bus with an eligible requester is granted next edge
  p_idle_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (!have_owner && |(req & ~blocked)) |=> |grant);
  // R7: an expiry pulse only follows an owned bus
  p_pulse_src_r7: assert property (@(posedge clk) disable iff (rst)
    hold_expired |-> $past(have_owner));
  // R9: disabled limit never pulses
  p_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (HOLD_LIMIT == 0) |-> !hold_expired);
endmodule

// File: tb/bus_owner_arbiter_tb_top.sv
module bus_owner_arbiter_tb_top;
  localparam int N = 3;

  typedef struct {
    int         due;
    logic [N-1:0] g4;
    logic       f4;
    logic [N-1:0] g0;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant4, grant0;
  logic exp4, exp0;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_owner_arbiter #(.NUM_MASTERS(N), .HOLD_LIMIT(4)) dut_i (
    .clk(clk), .rst(rst), .req(req), .grant(grant4), .hold_expired(exp4));
  bus_owner_arbiter #(.NUM_MASTERS(N), .HOLD_LIMIT(0)) dut_nolim (
    .clk(clk), .rst(rst), .req(req), .grant(grant0), .hold_expired(exp0));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: apply a request pattern and queue what must appear after the next edge
  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] g4,
                       input logic f4, input logic [N-1:0] g0, input string tag);
    exp_t e;
    @(negedge clk);
    req = r;
    e.due = cyc + 1; e.g4 = g4; e.f4 = f4; e.g0 = g0; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " grant"}, grant4, e.g4);
      chk({e.tag, " expired"}, {2'b00, exp4}, {2'b00, e.f4});
      chk({e.tag, " R9 grant nolimit"}, grant0, e.g0);
      chk("R9 nolimit flag", {2'b00, exp0}, 3'b000);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset grant", grant4, 3'b000);
    chk("R1 reset flag", {2'b00, exp4}, 3'b000);
    rst = 1'b0;
    drive(3'b000, 3'b000, 0, 3'b000, "R1 idle");
    drive(3'b011, 3'b001, 0, 3'b001, "R3 A+B");
    drive(3'b011, 3'b001, 0, 3'b001, "R4 A holds");
    drive(3'b010, 3'b010, 0, 3'b010, "R5 A->B");
    drive(3'b011, 3'b010, 0, 3'b010, "R4 no preempt");
    drive(3'b011, 3'b010, 0, 3'b010, "R4 B holds");
    drive(3'b001, 3'b001, 0, 3'b001, "R5 B->A");
    drive(3'b000, 3'b000, 0, 3'b000, "R5 to idle");
    drive(3'b100, 3'b100, 0, 3'b100, "R6 C from idle");
    drive(3'b110, 3'b100, 0, 3'b100, "R4 C holds");
    drive(3'b010, 3'b010, 0, 3'b010, "R5 C->B");
    drive(3'b000, 3'b000, 0, 3'b000, "R5 idle");
    drive(3'b100, 3'b100, 0, 3'b100, "R7 cycle1");
    drive(3'b100, 3'b100, 0, 3'b100, "R7 cycle2");
    drive(3'b100, 3'b100, 0, 3'b100, "R7 cycle3");
    drive(3'b100, 3'b100, 0, 3'b100, "R7 cycle4");
    drive(3'b110, 3'b010, 1, 3'b100, "R8 expire to B");
    drive(3'b110, 3'b010, 0, 3'b100, "R7 single pulse");
    drive(3'b100, 3'b000, 0, 3'b100, "R8 C blocked");
    drive(3'b100, 3'b000, 0, 3'b100, "R8 still blocked");
    drive(3'b000, 3'b000, 0, 3'b000, "R8 release");
    drive(3'b100, 3'b100, 0, 3'b100, "R8 unblocked");
    drive(3'b100, 3'b100, 0, 3'b100, "R10 hold2");
    drive(3'b100, 3'b100, 0, 3'b100, "R10 hold3");
    drive(3'b100, 3'b100, 0, 3'b100, "R10 hold4");
    drive(3'b000, 3'b000, 0, 3'b000, "R10 drop at limit");
    drive(3'b001, 3'b001, 0, 3'b001, "R7 A cycle1");
    drive(3'b001, 3'b001, 0, 3'b001, "R7 A cycle2");
    drive(3'b001, 3'b001, 0, 3'b001, "R7 A cycle3");
    drive(3'b001, 3'b001, 0, 3'b001, "R7 A cycle4");
    drive(3'b001, 3'b000, 1, 3'b001, "R7 expire idle");
    drive(3'b001, 3'b000, 0, 3'b001, "R8 A blocked");
    drive(3'b000, 3'b000, 0, 3'b000, "R8 A release");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule